// File: doc/BRIEF.md
# Concatenable Multi-Channel PWM Generator

This block produces eight pulse-width modulated outputs. Each channel has an 8-bit period, an 8-bit duty value, its own clock rate taken from a shared power-of-two prescaler, a polarity bit and an alignment choice. In left-aligned mode a channel counts up and wraps. In center-aligned mode it counts up and then back down, which doubles the period. A pair of neighbouring channels can be joined into one 16-bit channel. When a pair is joined, the even channel supplies the upper byte of period and duty. The odd channel supplies the lower byte and drives the output pin.

Software programs the block through a simple write port: an enable strobe, a register address and a data byte. New period and duty values are held aside and loaded only when the running period ends. A retuned channel therefore never emits a runt pulse.

A shutdown input overrides every pin at once with a programmable idle pattern. The override is combinational, so it takes effect without a clock. The input also sets a sticky flag, and the outputs stay idle until software clears that flag with the input released.

Top module: `pwm_concat_gen`

## Requirements
- R1: For a left-aligned channel with period P (address i for channel i), duty D (address 8+i) and clock exponent e, the output repeats every P·2^e cycles and is active for D·2^e of them when 0 < D < P. Alignment bit i of address 18 is 0 for left-aligned. Enable bit i lives at address 17 (polarity) / 16 (enable).
- R2: With bit i of address 18 set (center-aligned), the output repeats every 2·P·2^e cycles and is active for 2·min(D,P)·2^e of them.
- R3: A duty of 0 gives a constantly inactive output, and a duty of at least P gives a constantly active output, in either alignment.
- R4: Bit i of address 17 is the polarity: 1 makes the active level high, 0 makes it low. A channel whose enable bit (address 16) is 0 holds its inactive level. After reset all channels are disabled with polarity 1, so every pin is low.
- R5: Address 22+i holds the clock exponent e (0 to 7) of channel i, and the channel counter advances once every 2^e cycles.
- R6: Setting bit k of address 19 joins channels 2k and 2k+1. The period is 256·per[2k]+per[2k+1], and duty is formed the same way. The waveform appears on pin 2k+1 under the enable, polarity, alignment and clock exponent of channel 2k+1, and pin 2k stays low.
- R7: Period or duty values written while a channel runs take effect only at the start of its next period. A channel whose enable bit is 0 takes them at once.
- R8: While the shutdown input is high, the outputs equal the idle pattern at address 20 with no clock delay.
- R9: A high shutdown input sets the shutdown flag within three clock edges. While the flag is set, the outputs keep the idle pattern even after the input falls.
- R10: A write of a byte with bit 0 set to address 21 clears the flag only if the shutdown input has been low for at least two clock edges. Otherwise the write is ignored. Once the flag clears, the channel waveforms return on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| sd_pin | input | 1 | Emergency shutdown, active high, asynchronous |
| pwm_out | output | 8 | PWM output pins, bit i is channel i |
| sd_flag | output | 1 | Sticky shutdown flag |

## Verification
The hardest case to reach from the ports is a duty write that lands at a known point inside a running period, because the counter phase is not visible outside the block. The bench recovers that phase by waiting for the output's inactive-to-active edge, which marks the counter's return to zero. It then writes the new duty a fixed number of cycles later and counts active cycles in the rest of the current period separately from the next period. The waveform sweeps avoid any dependence on prescaler phase in another way. They count active cycles over a window that spans exactly two periods, so the count is the same wherever the window starts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } cnt_dir_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int NSEL = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [NSEL-1:0] tick
);
   localparam int CNTW = NSEL - 1;

   logic [CNTW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   assign tick[0] = 1'b1;

   for (genvar e = 1; e < NSEL; e++) begin : g_tap
      assign tick[e] = &cnt[e-1:0];
      if (e >= 2) begin : g_nest
         // R5: a slower tap only fires on a cycle where the next faster one fires
         a_r5_tick_nested: assert property (@(posedge clk) disable iff (!rst_n)
            tick[e] |-> tick[e-1]);
      end
   end
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
   import pwm_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic         center,
   input  logic [W-1:0] per_new,
   input  logic [W-1:0] dut_new,
   output logic         act
);
   logic [W-1:0] cnt, per_q, dut_q;
   cnt_dir_e     dir;
   logic         at_top, wrap;

   assign at_top = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, per_q};
   assign wrap   = center ? (dir == DIR_DOWN && cnt == '0) : at_top;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         dir   <= DIR_UP;
         per_q <= '0;
         dut_q <= '0;
      end else if (!en) begin
         cnt   <= '0;
         dir   <= DIR_UP;
         per_q <= per_new;
         dut_q <= dut_new;
      end else if (tick) begin
         if (wrap) begin
            cnt   <= '0;
            dir   <= DIR_UP;
            per_q <= per_new;
            dut_q <= dut_new;
         end else if (center && dir == DIR_UP && at_top) begin
            dir <= DIR_DOWN;
         end else if (center && dir == DIR_DOWN) begin
            cnt <= cnt - 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign act = en && (cnt < dut_q);

   // R1: the counter never reaches the active period value
   a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (en && per_q != '0) |-> (cnt < per_q));

   // R7: a running channel only swaps in new values at the end of a period
   a_r7_reload_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && (per_q != $past(per_q) || dut_q != $past(dut_q)))
         |-> $past(tick && wrap));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
   parameter int CW   = 8,
   parameter int NSEL = 8,
   localparam int SELW = $clog2(NSEL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      en,
   input  logic [1:0]      pol,
   input  logic [1:0]      center,
   input  logic            cat,
   input  logic [CW-1:0]   per_e,
   input  logic [CW-1:0]   per_o,
   input  logic [CW-1:0]   dut_e,
   input  logic [CW-1:0]   dut_o,
   input  logic [SELW-1:0] sel_e,
   input  logic [SELW-1:0] sel_o,
   input  logic [NSEL-1:0] ticks,
   output logic [1:0]      pin
);
   logic [2*CW-1:0] per_w, dut_w;
   logic            act_o, act_e;

   assign per_w = cat ? {per_e, per_o} : {{CW{1'b0}}, per_o};
   assign dut_w = cat ? {dut_e, dut_o} : {{CW{1'b0}}, dut_o};

   pwm_engine #(.W(2*CW)) u_odd (
      .clk(clk), .rst_n(rst_n), .en(en[1]), .tick(ticks[sel_o]),
      .center(center[1]), .per_new(per_w), .dut_new(dut_w), .act(act_o)
   );

   pwm_engine #(.W(CW)) u_even (
      .clk(clk), .rst_n(rst_n), .en(en[0] & ~cat), .tick(ticks[sel_e]),
      .center(center[0]), .per_new(per_e), .dut_new(dut_e), .act(act_e)
   );

   assign pin[1] = pol[1] ? act_o : ~act_o;
   assign pin[0] = cat ? 1'b0 : (pol[0] ? act_e : ~act_e);

   // R6: the even engine stays quiet while the pair is joined
   a_r6_even_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cat |-> !act_e);
endmodule

// File: rtl/pwm_shutdown.sv
module pwm_shutdown (
   input  logic clk,
   input  logic rst_n,
   input  logic sd_pin,
   input  logic clr_req,
   output logic flag,
   output logic force_idle
);
   logic [1:0] sync;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync <= '0;
         flag <= 1'b0;
      end else begin
         sync <= {sync[0], sd_pin};
         if (sync[1])      flag <= 1'b1;
         else if (clr_req) flag <= 1'b0;
      end
   end

   assign force_idle = sd_pin | flag;

   // R9: a synchronised shutdown always leaves the flag set
   a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      sync[1] |=> flag);

   // R10: the flag only drops after the pin was seen low
   a_r10_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(!sync[1] && clr_req));
endmodule

// File: rtl/pwm_concat_gen.sv
module pwm_concat_gen #(
   parameter  int NCH  = 8,
   parameter  int CW   = 8,
   parameter  int NSEL = 8,
   localparam int NPAIR = NCH / 2,
   localparam int SELW  = $clog2(NSEL),
   localparam int A_DUT = NCH,
   localparam int A_EN  = 2 * NCH,
   localparam int A_POL = A_EN + 1,
   localparam int A_CTR = A_EN + 2,
   localparam int A_CAT = A_EN + 3,
   localparam int A_IDL = A_EN + 4,
   localparam int A_CLR = A_EN + 5,
   localparam int A_SEL = A_EN + 6,
   localparam int NREG  = A_SEL + NCH,
   localparam int AW    = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [CW-1:0]  wr_data,
   input  logic           sd_pin,
   output logic [NCH-1:0] pwm_out,
   output logic           sd_flag
);
   if (NCH % 2 != 0) begin : g_bad_nch
      $error("NCH must be even");
   end
   if (NCH > CW) begin : g_bad_mask
      $error("channel masks must fit in one data word");
   end
   if ((1 << SELW) != NSEL || NSEL < 2) begin : g_bad_sel
      $error("NSEL must be a power of two, at least 2");
   end

   logic [CW-1:0]   per_q [NCH];
   logic [CW-1:0]   dut_q [NCH];
   logic [SELW-1:0] sel_q [NCH];
   logic [NCH-1:0]  en_q, pol_q, ctr_q, idle_q, raw;
   logic [NPAIR-1:0] cat_q;
   logic [NSEL-1:0] ticks;
   logic            clr_req, force_idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            per_q[i] <= '0;
            dut_q[i] <= '0;
            sel_q[i] <= '0;
         end
         en_q   <= '0;
         pol_q  <= '1;
         ctr_q  <= '0;
         idle_q <= '0;
         cat_q  <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NCH; i++) begin
            if (int'(wr_addr) == i)         per_q[i] <= wr_data;
            if (int'(wr_addr) == A_DUT + i) dut_q[i] <= wr_data;
            if (int'(wr_addr) == A_SEL + i) sel_q[i] <= wr_data[SELW-1:0];
         end
         if (int'(wr_addr) == A_EN)  en_q   <= wr_data[NCH-1:0];
         if (int'(wr_addr) == A_POL) pol_q  <= wr_data[NCH-1:0];
         if (int'(wr_addr) == A_CTR) ctr_q  <= wr_data[NCH-1:0];
         if (int'(wr_addr) == A_IDL) idle_q <= wr_data[NCH-1:0];
         if (int'(wr_addr) == A_CAT) cat_q  <= wr_data[NPAIR-1:0];
      end
   end

   assign clr_req = wr_en && (int'(wr_addr) == A_CLR) && wr_data[0];

   pwm_prescaler #(.NSEL(NSEL)) u_presc (
      .clk(clk), .rst_n(rst_n), .tick(ticks)
   );

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      pwm_pair #(.CW(CW), .NSEL(NSEL)) u_pair (
         .clk(clk), .rst_n(rst_n),
         .en(en_q[2*k+1:2*k]), .pol(pol_q[2*k+1:2*k]),
         .center(ctr_q[2*k+1:2*k]), .cat(cat_q[k]),
         .per_e(per_q[2*k]), .per_o(per_q[2*k+1]),
         .dut_e(dut_q[2*k]), .dut_o(dut_q[2*k+1]),
         .sel_e(sel_q[2*k]), .sel_o(sel_q[2*k+1]),
         .ticks(ticks), .pin(raw[2*k+1:2*k])
      );
   end

   pwm_shutdown u_sd (
      .clk(clk), .rst_n(rst_n), .sd_pin(sd_pin), .clr_req(clr_req),
      .flag(sd_flag), .force_idle(force_idle)
   );

   assign pwm_out = force_idle ? idle_q : raw;

   // R8: a high shutdown pin shows the idle pattern on every pin
   a_r8_idle_forced: assert property (@(posedge clk) disable iff (!rst_n)
      sd_pin |-> (pwm_out == idle_q));

   // R9: while the flag is held the pins cannot leave the idle pattern
   a_r9_flag_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sd_flag |-> (pwm_out == idle_q));
endmodule

// File: tb/test_pwm_concat_gen.sv
module test_pwm_concat_gen;
   localparam int A_DUT = 8, A_EN = 16, A_POL = 17, A_CTR = 18, A_CAT = 19;
   localparam int A_IDL = 20, A_CLR = 21, A_SEL = 22;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       sd_pin = 1'b0;
   logic [7:0] pwm_out;
   logic       sd_flag;

   int checks = 0;
   int errors = 0;
   logic [7:0] en_m = 8'h00, pol_m = 8'hFF, ctr_m = 8'h00;

   always #2 clk = ~clk;

   pwm_concat_gen i_pwm_concat_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sd_pin(sd_pin), .pwm_out(pwm_out), .sd_flag(sd_flag)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic measure(int ch, int len, int exp_hi, string tag);
      int h = 0;
      repeat (len + 2) @(negedge clk);
      for (int i = 0; i < 2 * len; i++) begin
         @(negedge clk);
         h += int'(pwm_out[ch]);
      end
      chk(tag, h, 2 * exp_hi);
   endtask

   task automatic setup(int ch, int p, int d, int e, bit ctr);
      en_m[ch] = 1'b0;  wr(A_EN, en_m);
      ctr_m[ch] = ctr;  wr(A_CTR, ctr_m);
      wr(ch, p); wr(A_DUT + ch, d); wr(A_SEL + ch, e);
      en_m[ch] = 1'b1;  wr(A_EN, en_m);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 reset state: disabled, polarity 1 -> all low; R9 flag clear
      chk("R4 reset pins", int'(pwm_out), 0);
      chk("R9 reset flag", int'(sd_flag), 0);

      // R1 / R3 left-aligned sweep on channel 0
      for (int p = 1; p <= 6; p++)
         for (int d = 0; d <= 7; d++) begin
            setup(0, p, d, 0, 1'b0);
            measure(0, p, (d < p) ? d : p, (d == 0 || d >= p) ? "R3 left" : "R1 left");
         end

      // R2 / R3 center-aligned sweep on channel 1
      for (int p = 1; p <= 5; p++)
         for (int d = 0; d <= 6; d++) begin
            setup(1, p, d, 0, 1'b1);
            measure(1, 2 * p, 2 * ((d < p) ? d : p),
                    (d == 0 || d >= p) ? "R3 center" : "R2 center");
         end

      // R5 clock exponent sweep on channel 2
      for (int e = 0; e <= 3; e++) begin
         setup(2, 5, 2, e, 1'b0);
         measure(2, 5 << e, 2 << e, "R5 left exponent");
      end
      setup(2, 3, 1, 2, 1'b1);
      measure(2, 6 << 2, 2 << 2, "R5 center exponent");

      // R4 polarity 0 makes the active level low
      pol_m[3] = 1'b0; wr(A_POL, pol_m);
      setup(3, 8, 3, 0, 1'b0);
      measure(3, 8, 5, "R4 active low");
      en_m[3] = 1'b0; wr(A_EN, en_m);
      repeat (2) @(negedge clk);
      chk("R4 disabled pol0 high", int'(pwm_out[3]), 1);
      pol_m[3] = 1'b1; wr(A_POL, pol_m);
      @(negedge clk);
      chk("R4 disabled pol1 low", int'(pwm_out[3]), 0);

      // R6 join channels 2 and 3: period 256*1+44=300, duty 100
      en_m[2] = 1'b0; en_m[3] = 1'b0; wr(A_EN, en_m);
      wr(A_CAT, 8'h02);
      wr(2, 1); wr(3, 44); wr(A_DUT + 2, 0); wr(A_DUT + 3, 100);
      wr(A_SEL + 3, 0);
      en_m[3] = 1'b1; wr(A_EN, en_m);
      measure(3, 300, 100, "R6 joined left");
      begin
         int h2 = 0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            h2 += int'(pwm_out[2]);
         end
         chk("R6 even pin low", h2, 0);
      end
      en_m[3] = 1'b0; wr(A_EN, en_m);
      ctr_m[3] = 1'b1; wr(A_CTR, ctr_m);
      en_m[3] = 1'b1; wr(A_EN, en_m);
      measure(3, 600, 200, "R6 joined center");

      // R7 duty written mid-period only applies to the next period
      setup(0, 10, 3, 0, 1'b0);
      repeat (30) @(negedge clk);
      begin
         logic prev, cur;
         int h;
         prev = pwm_out[0];
         forever begin
            @(negedge clk);
            cur = pwm_out[0];
            if (!prev && cur) break;
            prev = cur;
         end
         repeat (2) @(negedge clk);
         wr(A_DUT + 0, 7);
         h = int'(pwm_out[0]);
         for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            h += int'(pwm_out[0]);
         end
         chk("R7 rest of old period", h, 0);
         h = 0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            h += int'(pwm_out[0]);
         end
         chk("R7 next period", h, 7);
      end

      // R8 / R9 / R10 shutdown sequence
      wr(A_IDL, 8'hA5);
      @(negedge clk);
      sd_pin = 1'b1;
      #1;
      chk("R8 immediate idle", int'(pwm_out), 8'hA5);
      repeat (4) @(negedge clk);
      chk("R9 flag set", int'(sd_flag), 1);
      sd_pin = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 idle held", int'(pwm_out), 8'hA5);
      chk("R9 flag held", int'(sd_flag), 1);
      sd_pin = 1'b1;
      repeat (4) @(negedge clk);
      wr(A_CLR, 1);
      chk("R10 clear ignored", int'(sd_flag), 1);
      sd_pin = 1'b0;
      repeat (4) @(negedge clk);
      wr(A_CLR, 1);
      chk("R10 flag cleared", int'(sd_flag), 0);
      measure(0, 10, 7, "R10 waveform resumes");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule